// File: doc/BRIEF.md
# Variable-Length Prefix Item Parser

This block walks the prefix region at the front of an instruction block and cuts it into prefix items. Each item is 8, 16 or 32 bits long, and its own leading bits give that length. The items therefore have to be taken one after another. The block delivers one item per handshake to the decode stage, which pairs it with the next prefixed instruction. When the requested number of items has been delivered, the block reports how many whole 32-bit words the region took, so that later stages know where immediate operands begin.

A parse starts with a single-cycle `start_i`. That cycle supplies the whole block, a flag saying whether a reserved header word comes first, and the number of prefixed instructions that need a prefix. Items come out at most one per cycle through a valid/ready pair. A 16-bit item whose payload has three leading zeros is reported as a 12-bit prefix. A 32-bit item whose payload has six leading zeros is reported as a 24-bit prefix. If an item would extend past the end of the block, the parse stops and raises an error.

Top module: `pfx_stream_parser`

## Requirements
- R1: After reset, `item_valid_o`, `done_o`, `err_o` and `busy_o` are all low.
- R2: An item whose first bit is 0 is 16 bits long and its payload is bits 14:0. If payload bits 14:12 are not all zero, the kind is 2 (15-bit) and the value is the payload. If they are all zero, the kind is 1 (12-bit) and the value is payload bits 11:0.
- R3: An item whose first two bits are 10 is 8 bits long. Its kind is 0 (short) and its value is its low 6 bits.
- R4: An item whose first two bits are 11 is 32 bits long and its payload is bits 29:0. If payload bits 29:24 are not all zero, the kind is 4 (30-bit). If they are all zero, the kind is 3 (24-bit) and the value is bits 23:0. In every kind the value is zero-extended to 30 bits.
- R5: Block word k sits at `block_i[32k+31:32k]`, and each word is read from its most significant byte down. The items are delivered in stream order, back to back across word boundaries. One item passes on each cycle in which valid and ready are both high. Exactly `pfx_cnt_i` items are delivered.
- R6: With `hdr_skip_i` high, word 0 is skipped and the region starts at word 1. With it low, the region starts at word 0.
- R7: While `item_valid_o` is high and `item_ready_i` is low, the next cycle keeps valid high and keeps the value and kind unchanged.
- R8: `done_o` is high for exactly one cycle after the last item is accepted, or right after a start with a count of 0. During that cycle `words_used_o` equals the number of region bytes consumed divided by 4, rounded up.
- R9: If the next item would extend past the end of the block, `err_o` goes high and stays high until the next start. While `err_o` is high, neither valid nor done is asserted.
- R10: A start pulse that arrives while `busy_o` is high is ignored, and the item stream in progress continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a parse; accepted only when idle or in error |
| hdr_skip_i | input | 1 | Region starts after a reserved header word |
| pfx_cnt_i | input | 4 | Number of items to deliver |
| block_i | input | 256 | Whole instruction block, word k at bits 32k+31:32k |
| item_valid_o | output | 1 | An item is presented |
| item_ready_i | input | 1 | Consumer accepts the presented item |
| item_value_o | output | 30 | Prefix value, zero-extended |
| item_kind_o | output | 3 | 0 short, 1 12-bit, 2 15-bit, 3 24-bit, 4 30-bit |
| busy_o | output | 1 | Items are being delivered |
| done_o | output | 1 | One-cycle pulse when the parse ends |
| err_o | output | 1 | Item ran past the block end |
| words_used_o | output | 4 | Region words consumed, valid with done_o |

## Verification
The stimulus mixes all five item kinds in a single stream. This shows that length decoding moves the pointer correctly after each kind, and that the leading-zero forms are separated from the long forms, including all-zero payloads. Other streams place 16-bit and 32-bit items across word boundaries, with and without the header word, so that a fault in byte order or header offset shows up. Two boundary cases check the word count: a count of zero and a stream that fills the block exactly. A stream that runs off the end separates a correct overrun check from an off-by-one. Ready is driven three ways: always high, with a periodic gap, and held low long enough for a second start to arrive during the parse.

// File: rtl/pfx_pkg.sv
package pfx_pkg;
   typedef enum logic [2:0] {
      PK_S6  = 3'd0,
      PK_P12 = 3'd1,
      PK_P15 = 3'd2,
      PK_P24 = 3'd3,
      PK_P30 = 3'd4
   } pfx_kind_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_EMIT = 2'd1,
      ST_FIN  = 2'd2,
      ST_ERR  = 2'd3
   } pfx_state_e;
endpackage

// File: rtl/pfx_byte_window.sv
module pfx_byte_window #(
   parameter int BLK_WORDS = 8,
   parameter int IDX_W     = 6
) (
   input  logic [BLK_WORDS*32-1:0] blk_i,
   input  logic [IDX_W-1:0]        base_i,
   output logic [31:0]             win_o
);
   localparam int BLK_BYTES = BLK_WORDS * 4;
   localparam int AW        = $clog2(BLK_BYTES);

   logic [7:0] bytes_w [BLK_BYTES];

   // stream byte order: word by word, most significant byte first
   for (genvar gi = 0; gi < BLK_BYTES; gi++) begin : g_byte
      assign bytes_w[gi] = blk_i[(gi/4)*32 + (3-(gi%4))*8 +: 8];
   end

   for (genvar gk = 0; gk < 4; gk++) begin : g_lane
      logic [IDX_W-1:0] idx;
      assign idx = base_i + IDX_W'(gk);
      assign win_o[31-8*gk -: 8] = (idx < IDX_W'(BLK_BYTES)) ? bytes_w[idx[AW-1:0]] : 8'h00;
   end
endmodule

// File: rtl/pfx_item_decode.sv
module pfx_item_decode
   import pfx_pkg::*;
(
   input  logic [31:0] win_i,
   output logic [2:0]  len_o,
   output pfx_kind_e   kind_o,
   output logic [29:0] value_o
);
   logic [14:0] pay15;
   logic [29:0] pay30;

   assign pay15 = win_i[30:16];
   assign pay30 = win_i[29:0];

   always_comb begin
      if (!win_i[31]) begin
         len_o = 3'd2;
         if (pay15[14:12] == 3'b000) begin
            kind_o  = PK_P12;
            value_o = {18'd0, pay15[11:0]};
         end else begin
            kind_o  = PK_P15;
            value_o = {15'd0, pay15};
         end
      end else if (!win_i[30]) begin
         len_o   = 3'd1;
         kind_o  = PK_S6;
         value_o = {24'd0, win_i[29:24]};
      end else begin
         len_o = 3'd4;
         if (pay30[29:24] == 6'd0) begin
            kind_o  = PK_P24;
            value_o = {6'd0, pay30[23:0]};
         end else begin
            kind_o  = PK_P30;
            value_o = pay30;
         end
      end
   end

   always_comb begin
      if (kind_o == PK_P12) assert_short12_R2: assert (value_o[29:12] == '0);
      if (kind_o == PK_P24) assert_short24_R4: assert (value_o[29:24] == '0);
   end
endmodule

// File: rtl/pfx_stream_parser.sv
module pfx_stream_parser
   import pfx_pkg::*;
#(
   parameter int BLK_WORDS = 8,
   parameter bit HDR_EN    = 1'b1,
   localparam int BLK_BYTES = BLK_WORDS * 4,
   localparam int BLK_BITS  = BLK_WORDS * 32,
   localparam int IDX_W     = $clog2(BLK_BYTES + 4),
   localparam int CNT_W     = $clog2(BLK_WORDS + 1)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start_i,
   input  logic                hdr_skip_i,
   input  logic [CNT_W-1:0]    pfx_cnt_i,
   input  logic [BLK_BITS-1:0] block_i,
   output logic                item_valid_o,
   input  logic                item_ready_i,
   output logic [29:0]         item_value_o,
   output logic [2:0]          item_kind_o,
   output logic                busy_o,
   output logic                done_o,
   output logic                err_o,
   output logic [CNT_W-1:0]    words_used_o
);
   if (BLK_WORDS < 2) begin : g_bad_words
      $error("BLK_WORDS must be at least 2");
   end
   if (BLK_WORDS > 64) begin : g_big_words
      $error("BLK_WORDS too large for window logic");
   end

   pfx_state_e          state_q;
   logic [BLK_BITS-1:0] blk_q;
   logic                hdr_q;
   logic                hdr_in;
   logic [IDX_W-1:0]    ptr_q;
   logic [CNT_W-1:0]    rem_q;

   if (HDR_EN) begin : g_hdr
      assign hdr_in = hdr_skip_i;
   end else begin : g_nohdr
      assign hdr_in = 1'b0;
   end

   logic [IDX_W-1:0] base_w, lim_w, nxt_w;
   logic [31:0]      win_w;
   logic [2:0]       len_w;
   pfx_kind_e        kind_w;
   logic [29:0]      val_w;
   logic             overrun_w, accept_w;

   assign base_w = ptr_q + (hdr_q ? IDX_W'(4) : IDX_W'(0));
   assign lim_w  = IDX_W'(BLK_BYTES) - (hdr_q ? IDX_W'(4) : IDX_W'(0));

   pfx_byte_window #(.BLK_WORDS(BLK_WORDS), .IDX_W(IDX_W)) win_i (
      .blk_i (blk_q),
      .base_i(base_w),
      .win_o (win_w)
   );

   pfx_item_decode dec_i (
      .win_i  (win_w),
      .len_o  (len_w),
      .kind_o (kind_w),
      .value_o(val_w)
   );

   assign nxt_w     = ptr_q + IDX_W'(len_w);
   assign overrun_w = nxt_w > lim_w;

   assign item_valid_o = (state_q == ST_EMIT) && (rem_q != '0) && !overrun_w;
   assign item_value_o = val_w;
   assign item_kind_o  = kind_w;
   assign accept_w     = item_valid_o && item_ready_i;
   assign busy_o       = state_q == ST_EMIT;
   assign done_o       = state_q == ST_FIN;
   assign err_o        = state_q == ST_ERR;
   assign words_used_o = CNT_W'((ptr_q + IDX_W'(3)) >> 2);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         blk_q   <= '0;
         hdr_q   <= 1'b0;
         ptr_q   <= '0;
         rem_q   <= '0;
      end else begin
         unique case (state_q)
            ST_IDLE, ST_ERR: begin
               if (start_i) begin
                  blk_q   <= block_i;
                  hdr_q   <= hdr_in;
                  ptr_q   <= '0;
                  rem_q   <= pfx_cnt_i;
                  state_q <= (pfx_cnt_i == '0) ? ST_FIN : ST_EMIT;
               end
            end
            ST_EMIT: begin
               if (overrun_w) begin
                  state_q <= ST_ERR;
               end else if (accept_w) begin
                  ptr_q <= nxt_w;
                  rem_q <= rem_q - CNT_W'(1);
                  if (rem_q == CNT_W'(1)) state_q <= ST_FIN;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (item_valid_o && !item_ready_i) |=>
         (item_valid_o && $stable(item_value_o) && $stable(item_kind_o)));

   assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   assert_words_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (words_used_o <= CNT_W'(BLK_WORDS)));

   assert_err_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      err_o |-> (!item_valid_o && !done_o));

   assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (err_o && !start_i) |=> err_o);

   assert_busy_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && start_i && !accept_w && !overrun_w) |=>
         ($stable(item_value_o) && $stable(item_kind_o) && busy_o));
endmodule

// File: tb/pfx_stream_parser_tb_top.sv
module pfx_stream_parser_tb_top;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         start = 1'b0;
   logic         hdr_skip = 1'b0;
   logic [3:0]   cnt = '0;
   logic [255:0] block = '0;
   logic         valid, ready, busy, done, err;
   logic [29:0]  value;
   logic [2:0]   kind;
   logic [3:0]   words;

   always #5 clk = ~clk;

   pfx_stream_parser dut_i (
      .clk(clk), .rst_n(rst_n), .start_i(start), .hdr_skip_i(hdr_skip),
      .pfx_cnt_i(cnt), .block_i(block), .item_valid_o(valid),
      .item_ready_i(ready), .item_value_o(value), .item_kind_o(kind),
      .busy_o(busy), .done_o(done), .err_o(err), .words_used_o(words)
   );

   int total = 0;
   int fails = 0;
   logic [7:0]  stream[$];
   logic [32:0] expq[$];
   int rmode = 0;
   int stall = 0;
   int cyc = 0;
   bit summary_done = 0;

   task automatic check(input bit ok, input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic summary();
      if (!summary_done) begin
         summary_done = 1;
         $display("%0d/%0d checks passed", total - fails, total);
      end
   endtask

   // kinds: 0 short6, 1 p12, 2 p15, 3 p24, 4 p30
   task automatic add_item(input int k, input logic [29:0] v);
      logic [31:0] enc;
      case (k)
         0: begin enc = {2'b10, v[5:0], 24'd0}; stream.push_back(enc[31:24]); end
         1, 2: begin
            enc = {1'b0, (k == 1) ? {3'b000, v[11:0]} : v[14:0], 16'd0};
            stream.push_back(enc[31:24]); stream.push_back(enc[23:16]);
         end
         default: begin
            enc = {2'b11, (k == 3) ? {6'd0, v[23:0]} : v};
            stream.push_back(enc[31:24]); stream.push_back(enc[23:16]);
            stream.push_back(enc[15:8]);  stream.push_back(enc[7:0]);
         end
      endcase
      expq.push_back({k[2:0], v});
   endtask

   // monitor: drives ready, then compares accepted items against the queue
   initial begin
      logic        held = 0;
      logic [32:0] hv = '0;
      logic [32:0] e;
      ready = 1'b0;
      forever begin
         @(negedge clk);
         cyc++;
         case (rmode)
            0: ready = 1'b1;
            1: ready = (cyc % 3) != 0;
            default: begin
               ready = (stall == 0);
               if (stall > 0) stall--;
            end
         endcase
         #1;
         if (held) begin
            check(valid && ({kind, value} == hv), "R7", "held item", {valid, kind, value[27:0]}, {1'b1, hv[32:30], hv[27:0]});
            held = 0;
         end
         if (valid && ready) begin
            if (expq.size() == 0) begin
               check(0, "R5", "unexpected item", {kind, value[28:0]}, 32'd0);
            end else begin
               e = expq.pop_front();
               check(kind == e[32:30], "R2 R3 R4", "item kind", {29'd0, kind}, {29'd0, e[32:30]});
               check(value == e[29:0], "R2 R3 R4 R5", "item value", {2'd0, value}, {2'd0, e[29:0]});
            end
         end else if (valid) begin
            held = 1;
            hv = {kind, value};
         end
      end
   end

   task automatic run_case(input bit hdr, input int n, input int ewords, input bit eerr,
                           input int mode, input bit restart);
      logic [255:0] blk;
      int a;
      int t;
      blk = '0;
      if (hdr) blk[31:0] = 32'hEEEE_EEEE;
      for (int i = 0; i < stream.size(); i++) begin
         a = (hdr ? 4 : 0) + i;
         blk[(a/4)*32 + (3-(a%4))*8 +: 8] = stream[i];
      end
      rmode = mode;
      stall = 6;
      @(negedge clk);
      hdr_skip = hdr; cnt = 4'(n); block = blk; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      if (restart) begin
         @(negedge clk);
         // R10: second start while busy must be ignored
         start = 1'b1; cnt = 4'd0; block = '0; hdr_skip = 1'b0;
         @(negedge clk);
         start = 1'b0;
      end
      t = 0;
      #2;
      while (!(done || err) && t < 400) begin
         @(negedge clk);
         #2;
         t++;
      end
      if (eerr) begin
         check(err == 1'b1, "R9", "error raised", {31'd0, err}, 32'd1);
         check(valid == 1'b0 && done == 1'b0, "R9", "quiet in error", {30'd0, valid, done}, 32'd0);
         check(expq.size() == 0, "R9", "items before overrun", expq.size(), 32'd0);
         repeat (3) @(negedge clk);
         #2;
         check(err == 1'b1, "R9", "error held", {31'd0, err}, 32'd1);
      end else begin
         check(done == 1'b1 && err == 1'b0, "R8", "done seen", {30'd0, done, err}, 32'd2);
         check(words == 4'(ewords), "R8", "words used", {28'd0, words}, ewords);
         check(expq.size() == 0, "R5", "all items delivered", expq.size(), 32'd0);
         @(negedge clk);
         #2;
         check(done == 1'b0, "R8", "done one cycle", {31'd0, done}, 32'd0);
      end
      stream.delete();
      expq.delete();
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      check(0, "WDOG", "watchdog expired", 32'd0, 32'd1);
      summary();
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      #2;
      check(!valid && !done && !err && !busy, "R1", "reset outputs",
            {28'd0, valid, done, err, busy}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      #2;
      check(!valid && !done && !err && !busy, "R1", "idle after reset",
            {28'd0, valid, done, err, busy}, 32'd0);

      // mixed kinds, region at word 0, gapped ready: 13 bytes -> 4 words
      add_item(0, 30'h2A);
      add_item(2, 30'h5123);
      add_item(1, 30'hABC);
      add_item(4, 30'h2345_6789);
      add_item(3, 30'hC0FFEE);
      run_case(1'b0, 5, 4, 1'b0, 1, 1'b0);

      // R6 header skip, boundary straddles, zero payloads, R10 restart: 14 bytes -> 4 words
      add_item(4, 30'h3FFF_FFFF);
      add_item(0, 30'h0);
      add_item(3, 30'h000001);
      add_item(2, 30'h7FFF);
      add_item(1, 30'h000);
      add_item(0, 30'h3F);
      run_case(1'b1, 6, 4, 1'b0, 2, 1'b1);

      // R8 count zero -> 0 words
      run_case(1'b0, 0, 0, 1'b0, 0, 1'b0);

      // R8 exact fill of the block: 8 long items -> 8 words
      for (int i = 0; i < 8; i++) add_item(4, 30'h1000_0000 + 30'(i * 7));
      run_case(1'b0, 8, 8, 1'b0, 0, 1'b0);

      // R9 overrun: header word plus 7 long items fills region, 8th runs off
      for (int i = 0; i < 7; i++) add_item(3, 30'(i + 1));
      run_case(1'b1, 8, 0, 1'b1, 0, 1'b0);

      // 16-bit item across a word boundary, start out of error: 5 bytes -> 2 words
      add_item(0, 30'h01);
      add_item(0, 30'h15);
      add_item(0, 30'h20);
      add_item(2, 30'h4321);
      run_case(1'b0, 4, 2, 1'b0, 1, 1'b0);
      check(err == 1'b0, "R9", "error cleared by start", {31'd0, err}, 32'd0);

      summary();
      $finish;
   end
endmodule